// File: doc/BRIEF.md
# Command-Steered Serial Register Slave

This block is a synchronous serial slave that lets a host reach a small bank of configuration and result registers over a clocked serial link. Every access begins with one command byte. The slave always takes that byte as a write to its communications register. The byte names a target register and a direction, and the slave then routes the next transfer to that register. When the target register has been fully transferred, the slave treats the following eight clocks as a new command byte. Core logic loads conversion results through a parallel port with a one-cycle strobe. A ready flag, active low, marks a fresh result that has not yet been read.

The link is half-duplex and uses clock phase 1: the slave changes its output on the leading edge of each serial clock and samples its input on the trailing edge. A polarity input sets which serial clock level counts as idle. Chip select may be held low for good, in which case bits are framed only by counting clocks. A 24-bit register may move as one burst or as separate bytes with pauses between them, and the slave keeps its place in the register across those pauses. The serial inputs are sampled in the `clk` domain, so each serial clock phase must last at least two `clk` cycles.

Top module: `serreg_slave`

## Requirements
- R1: After reset, `rdy_n` is 1, `dout` is 0 and all writable registers read 0. The first 8 serial clocks form a command byte.
- R2: A command byte, with bits [6:4] as the register select and bit 3 as the direction (1 = read), may be followed at once by an 8-bit write in a single unbroken 16-clock transfer. Select 1 is an 8-bit mode register and select 2 is an 8-bit control register, and both can be read and written.
- R3: Select 3 is a 24-bit coefficient register that can be read and written in one contiguous 24-clock transfer.
- R4: A 24-bit transfer may be broken into bytes, with `cs_n` taken high or the clock paused between bytes, and the slave keeps its position. If `cs_n` goes high in the middle of a byte, the partial byte is discarded and that byte starts over.
- R5: `dout` is 0 throughout command bytes and write accesses. `din` is ignored during read accesses and leaves every register unchanged.
- R6: With `pol`=0 the clock idles low, with `pol`=1 it idles high. In both cases the slave drives data on the leading edge and samples on the trailing edge.
- R7: A pulse on `ld_stb` loads `ld_data` into the 24-bit read-only data register (select 5) and drives `rdy_n` low. `rdy_n` goes high once all 24 bits of a data read have been shifted out, unless a new load arrived during that read. A load during a read does not change the word being shifted. A read of select 0 returns `rdy_n` in bit 7 and zeros in bits 6:0.
- R8: Data moves most-significant bit first in both directions.
- R9: A command that selects 4, 6 or 7, a write to select 0 and a write to select 5 are all ignored, and the next 8 clocks form a new command byte.
- R10: The slave works with `cs_n` held low for the whole session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select (may be tied low) |
| din | input | 1 | Serial data from the host |
| pol | input | 1 | Serial clock idle level select |
| ld_stb | input | 1 | One-cycle strobe that loads a new result |
| ld_data | input | 24 | Result word from core logic |
| dout | output | 1 | Serial data to the host, 0 when not reading |
| rdy_n | output | 1 | Active-low new-result flag |

## Verification
Combined 16-clock command-plus-data writes are read back and compared with three other write shapes: split command and data, contiguous 24-bit writes, and writes restarted after a partial byte. This exposes a slave that loses sync at the command boundary or keeps stale bits. Data reads are tried three ways: contiguous, split by chip select pulses and clock pauses, and overlapped by a new load. Together these show whether position tracking, word capture and the ready flag clearing behave as intended. Ignored commands, and reads with `din` held high, are each followed by a known readback, which shows that the bit counting stayed aligned. The full sequence is repeated with the opposite clock polarity and chip select held low.

// File: rtl/serreg_slave.sv
module serreg_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        din,
  input  logic        pol,
  input  logic        ld_stb,
  input  logic [23:0] ld_data,
  output logic        dout,
  output logic        rdy_n
);
  localparam logic [2:0] A_COMM = 3'd0, A_MODE = 3'd1, A_CTRL = 3'd2,
                         A_COEF = 3'd3, A_DATA = 3'd5;

  logic        s_prev, acc_ph, rd_q, wide_q, dbit, rdy, reload;
  logic [2:0]  tgt;
  logic [4:0]  bcnt;
  logic [7:0]  bsh, mode_q, ctrl_q;
  logic [15:0] hold;
  logic [23:0] rd_word, data_q, coef_q, rd_sel;

  wire        s_now  = sclk ^ pol;
  wire        lead   = !cs_n && s_now && !s_prev;
  wire        trail  = !cs_n && !s_now && s_prev;
  wire [7:0]  byte_n = {bsh[6:0], din};
  wire [4:0]  bcnt_n = bcnt + 5'd1;
  wire [4:0]  last   = wide_q ? 5'd24 : 5'd8;
  wire [2:0]  csel   = byte_n[6:4];
  wire        crd    = byte_n[3];
  wire        cmd_end = trail && !acc_ph && bcnt == 5'd7;
  wire        cimpl  = (csel == A_COMM && crd) || csel == A_MODE || csel == A_CTRL ||
                       csel == A_COEF || (csel == A_DATA && crd);
  wire        done   = trail && acc_ph && bcnt_n == last;
  wire        start_data = cmd_end && cimpl && csel == A_DATA;

  always_comb begin
    case (csel)
      A_COMM:  rd_sel = {~rdy, 23'd0};
      A_MODE:  rd_sel = {mode_q, 16'd0};
      A_CTRL:  rd_sel = {ctrl_q, 16'd0};
      A_COEF:  rd_sel = coef_q;
      A_DATA:  rd_sel = data_q;
      default: rd_sel = 24'd0;
    endcase
  end

  assign dout  = acc_ph & rd_q & dbit;
  assign rdy_n = ~rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0; acc_ph <= 1'b0; rd_q <= 1'b0; wide_q <= 1'b0;
      dbit <= 1'b0; tgt <= A_COMM; bcnt <= 5'd0; bsh <= 8'd0;
      hold <= 16'd0; rd_word <= 24'd0; mode_q <= 8'd0; ctrl_q <= 8'd0;
      coef_q <= 24'd0;
    end else begin
      s_prev <= s_now;
      if (cs_n) begin
        bcnt <= {bcnt[4:3], 3'b000};
      end else if (lead) begin
        dbit <= rd_word[5'd23 - bcnt];
      end else if (trail) begin
        bsh <= byte_n;
        if (!acc_ph) begin
          if (bcnt == 5'd7) begin
            bcnt <= 5'd0;
            dbit <= 1'b0;
            if (cimpl) begin
              acc_ph  <= 1'b1;
              tgt     <= csel;
              rd_q    <= crd;
              wide_q  <= (csel == A_COEF) || (csel == A_DATA);
              rd_word <= rd_sel;
            end
          end else begin
            bcnt <= bcnt_n;
          end
        end else begin
          if (!rd_q && bcnt[2:0] == 3'd7) hold <= {hold[7:0], byte_n};
          if (bcnt_n == last) begin
            acc_ph <= 1'b0;
            bcnt   <= 5'd0;
            if (!rd_q) begin
              case (tgt)
                A_MODE:  mode_q <= byte_n;
                A_CTRL:  ctrl_q <= byte_n;
                A_COEF:  coef_q <= {hold, byte_n};
                default: ;
              endcase
            end
          end else begin
            bcnt <= bcnt_n;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 24'd0; rdy <= 1'b0; reload <= 1'b0;
    end else begin
      if (ld_stb) data_q <= ld_data;
      if (ld_stb) rdy <= 1'b1;
      else if (done && rd_q && tgt == A_DATA && !reload) rdy <= 1'b0;
      if (start_data) reload <= ld_stb;
      else if (ld_stb) reload <= 1'b1;
    end
  end

  // R7
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_stb |=> !rdy_n);
  // R4
  cs_align_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> bcnt[2:0] == 3'd0);
  // R1
  comm_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) !acc_ph |-> bcnt < 5'd8);
  // R3
  acc_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_ph |-> bcnt < last);
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ph && $past(acc_ph)) |-> $stable(rd_word));
  // R2
  mode_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(trail));
endmodule

// File: tb/sim_serreg_slave.sv
module sim_serreg_slave;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 0, din = 0, pol = 0, ld_stb = 0;
  logic [23:0] ld_data = 0;
  wire dout, rdy_n;

  always #2 clk = ~clk;

  serreg_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
                   .pol(pol), .ld_stb(ld_stb), .ld_data(ld_data), .dout(dout), .rdy_n(rdy_n));

  typedef struct { logic [23:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [23:0] got_q[$];
  item_t e_it;
  logic [23:0] g_v;
  int nrun = 0, nfail = 0, idle_bad = 0;
  bit idle_chk = 0;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      e_it = exp_q.pop_front();
      g_v  = got_q.pop_front();
      check(e_it.tag, g_v, e_it.v);
    end

  task automatic pause(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic sb(input logic o, output logic i);
    @(negedge clk); sclk = ~pol; din = o;
    repeat (4) @(negedge clk);
    i = dout;
    if (idle_chk && dout !== 1'b0) idle_bad++;
    sclk = pol;
    repeat (4) @(negedge clk);
    if (idle_chk && dout !== 1'b0) idle_bad++;
  endtask

  task automatic xfer(input logic [23:0] v, input int n, output logic [23:0] rx);
    logic b;
    rx = 0;
    for (int k = n - 1; k >= 0; k--) begin
      sb(v[k], b);
      rx = {rx[22:0], b};
    end
  endtask

  task automatic wr16(input logic [7:0] cmd, input logic [7:0] d, string tag);
    logic [23:0] r;
    idle_chk = 1; idle_bad = 0;
    xfer({8'd0, cmd, d}, 16, r);
    idle_chk = 0;
    check({tag, " dout idle"}, idle_bad, 0);
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [23:0] d, input int n, string tag);
    logic [23:0] r;
    idle_chk = 1; idle_bad = 0;
    xfer({16'd0, cmd}, 8, r);
    xfer(d, n, r);
    idle_chk = 0;
    check({tag, " dout idle"}, idle_bad, 0);
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, input logic [23:0] pat,
                    input logic [23:0] exp, string tag);
    logic [23:0] r;
    exp_q.push_back('{exp, tag});
    xfer({16'd0, cmd}, 8, r);
    xfer(pat, n, r);
    got_q.push_back(r);
  endtask

  task automatic load(input logic [23:0] v);
    @(negedge clk); ld_data = v; ld_stb = 1;
    @(negedge clk); ld_stb = 0;
  endtask

  task automatic split_data_read(input logic [23:0] exp, string tag, input bit use_cs);
    logic [23:0] a, b, c;
    exp_q.push_back('{exp, tag});
    xfer(24'h58, 8, a);
    if (use_cs) begin cs_n = 1; pause(6); cs_n = 0; end
    xfer(0, 8, a);
    if (use_cs) begin cs_n = 1; pause(6); cs_n = 0; end else pause(20);
    xfer(0, 8, b);
    pause(25);
    xfer(0, 8, c);
    got_q.push_back({a[7:0], b[7:0], c[7:0]});
  endtask

  task automatic suite(string p);
    logic [23:0] a, b;
    wr16(8'h10, 8'hA5, {p, " R2 combined write"});
    rd(8'h18, 8, 0, 24'hA5, {p, " R2 R8 mode readback"});
    wr(8'h20, 24'h3C, 8, {p, " R2 ctrl write"});
    rd(8'h28, 8, 0, 24'h3C, {p, " R2 ctrl readback"});
    wr(8'h30, 24'h123456, 24, {p, " R3 coef write"});
    rd(8'h38, 24, 0, 24'h123456, {p, " R3 coef contiguous read"});
    load(24'hC0FFEE);
    check({p, " R7 rdy_n low after load"}, rdy_n, 0);
    rd(8'h08, 8, 0, 24'h00, {p, " R7 comm bit7 ready"});
    split_data_read(24'hC0FFEE, {p, " R4 split data read"}, pol == 0);
    pause(2);
    check({p, " R7 rdy_n high after read"}, rdy_n, 1);
    rd(8'h08, 8, 0, 24'h80, {p, " R7 comm bit7 idle"});
    xfer(24'h20, 8, a);
    xfer(24'h5, 3, a);
    if (pol == 0) begin cs_n = 1; pause(6); cs_n = 0; xfer(24'h69, 8, a); end
    else xfer(24'h0D, 5, a);
    rd(8'h28, 8, 0, pol == 0 ? 24'h69 : 24'hAD, {p, " R4 partial byte"});
    xfer(24'h40, 8, a);
    rd(8'h18, 8, 0, 24'hA5, {p, " R9 unimplemented select ignored"});
    xfer(24'h50, 8, a);
    xfer(24'h00, 8, a);
    rd(8'h18, 8, 0, 24'hA5, {p, " R9 data write and comm write ignored"});
    rd(8'h18, 8, 24'hFF, 24'hA5, {p, " R5 din high during read"});
    rd(8'h18, 8, 0, 24'hA5, {p, " R5 mode unchanged after read"});
    load(24'h111111);
    exp_q.push_back('{24'h111111, {p, " R7 load during read keeps word"}});
    xfer(24'h58, 8, a);
    xfer(0, 8, a);
    load(24'h222222);
    xfer(0, 16, b);
    got_q.push_back({a[7:0], b[15:0]});
    pause(2);
    check({p, " R7 rdy_n stays low after overlapped load"}, rdy_n, 0);
    rd(8'h58, 24, 0, 24'h222222, {p, " R7 second result"});
    pause(2);
    check({p, " R7 rdy_n high after second read"}, rdy_n, 1);
  endtask

  initial begin
    pause(3);
    check("R1 rdy_n at reset", rdy_n, 1);
    check("R1 dout at reset", dout, 0);
    rst_n = 1;
    pause(3);
    rd(8'h18, 8, 0, 24'h00, "R1 mode reset value");
    rd(8'h38, 24, 0, 24'h000000, "R1 coef reset value");
    suite("pol0");
    @(negedge clk); pol = 1; sclk = 1;
    pause(4);
    suite("pol1 R6 R10");
    pause(10);
    check("scoreboard drained", exp_q.size() + got_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nrun++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule